// File: doc/BRIEF.md
# Three-Switch Inverter PWM Gate Generator

This block drives the three power switches of a single-phase, three-switch impedance-network inverter. A free-running carrier counter is compared against two thresholds. One threshold comes from a fixed boost setting and gives the first switch a constant duty. The other comes from a sine-weighted reference and gives the second switch a duty that follows a sinusoid around a DC offset. The third gate is the exclusive-OR of the first two. When the gain does not exceed the boost ratio, exactly two switches conduct at every instant.

The sine reference comes from a quarter-wave table that is computed at elaboration and mirrored into four quadrants. The reference advances one step per carrier period. Both thresholds are worked out in fixed point from the live settings and are latched only at the carrier wrap, so each period carries one consistent duty. A one-cycle strobe marks the start of the carrier period that uses sine sample zero, so the caller can line up each period with its sample index.

Top module: `tri_switch_pwm`

## Requirements
- R1: All three gates and the strobe are low while `rst_n` is low, which acts at once and asynchronously. They are also low from the first clock edge at which `en` is sampled low.
- R2: While enabled, the carrier counts 0 to PERIOD-1 and then wraps, so every carrier period lasts exactly PERIOD clock cycles.
- R3: `g_s1` is high in the first th1 cycles of each period and low for the rest of it. th1 = floor(PERIOD·k/(k+1)), where k is `k_set` read as unsigned with 4 fraction bits.
- R4: `g_s2` is low in the first th2 cycles of each period and high from then to the end of the period. th2 = floor(PERIOD·(k + A·s)/(2(k+1))), clamped to the range 0..PERIOD. A is `gain_set` read as unsigned with 6 fraction bits. s is sine sample n for carrier period n after enable, with s(n) = round(sin(2πn/(4·QUARTER))·(2^14−1))/2^14 and n taken modulo 4·QUARTER.
- R5: `g_s3` equals `g_s1` XOR `g_s2` in every cycle.
- R6: When A ≤ k, exactly two of the three gates are high in every enabled cycle.
- R7: A change of `k_set` or `gain_set` in the middle of a period does not alter that period. It takes effect from the next period.
- R8: `sine_strobe` is high for exactly one cycle, the first cycle of each period that uses sine sample 0. So it recurs every 4·QUARTER periods.
- R9: The first carrier period begins in the cycle after `en` is first sampled high, and it uses sine sample 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en | input | 1 | Run enable; low stops and rewinds the carrier and the sine phase |
| k_set | input | KW (8) | Boost ratio k, unsigned, 4 fraction bits |
| gain_set | input | GW (8) | Peak gain A, unsigned, 6 fraction bits |
| g_s1 | output | 1 | Gate of the boost switch |
| g_s2 | output | 1 | Gate of the sine-modulated switch |
| g_s3 | output | 1 | Gate of the third switch (XOR of the other two) |
| sine_strobe | output | 1 | One-cycle pulse at the start of the sample-zero period |

## Verification
On every cycle, the assertions check the following: the carrier stays inside its range and restarts after a wrap; the gates stay low once enable is sampled low; the latched thresholds change only at a wrap; the strobe is a single pulse at count zero; and the two-switches-on rule holds whenever the latched gain does not exceed the boost ratio. The bench scenarios show the rest. They check the actual duty count and the position of each gate against the formulas over a whole sine period for several settings. They also cover k = 0, the clamp of the sine threshold when A > k, a settings change in the middle of a period, and the restart of the sine phase after enable.

// File: rtl/tsp_pkg.sv
package tsp_pkg;
  // Sine quadrant sequence; order is behaviour (rise, fall, negative fall, negative rise)
  typedef enum logic [1:0] {
    QD_RISE    = 2'd0,
    QD_FALL    = 2'd1,
    QD_NFALL   = 2'd2,
    QD_NRISE   = 2'd3
  } quad_e;

  localparam int KF_DEF = 4;   // boost ratio fraction bits
  localparam int GF_DEF = 6;   // gain fraction bits
  localparam int SF_DEF = 14;  // sine sample fraction bits
endpackage

// File: rtl/tsp_carrier.sv
module tsp_carrier #(
  parameter int PERIOD = 12500,
  parameter int TW     = $clog2(PERIOD + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  output logic [TW-1:0] cnt,
  output logic          wrap
);
  localparam logic [TW-1:0] LAST = TW'(PERIOD - 1);

  logic [TW-1:0] cnt_d;

  assign wrap = en && (cnt == LAST);

  always_comb begin
    cnt_d = cnt;
    if (!en)       cnt_d = LAST;
    else if (wrap) cnt_d = '0;
    else           cnt_d = cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= LAST;
    else        cnt <= cnt_d;
  end

  // R2: counter never leaves 0..PERIOD-1
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST);

  // R2: a wrap always restarts the count at zero
  p_wrap_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> (cnt == '0));
endmodule

// File: rtl/tsp_sine_ref.sv
module tsp_sine_ref
  import tsp_pkg::*;
#(
  parameter int QUARTER = 100,
  parameter int SF      = SF_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  output logic signed [SF:0] sample,
  output logic              at_zero
);
  localparam int POS_W = $clog2(QUARTER);
  localparam int IDX_W = $clog2(QUARTER + 1);
  localparam int FULL  = (1 << SF) - 1;

  function automatic int lut_val(input int j);
    real ang;
    ang = 1.5707963267948966 * j / QUARTER;
    return int'($sin(ang) * FULL);
  endfunction

  logic [SF-1:0] tbl [0:QUARTER];

  for (genvar j = 0; j <= QUARTER; j++) begin : g_lut
    localparam logic [SF-1:0] VAL = SF'(lut_val(j));
    assign tbl[j] = VAL;
  end

  logic [POS_W-1:0] pos_q, pos_d;
  quad_e            quad_q, quad_d;
  logic [IDX_W-1:0] idx;
  logic             mirror, negate;
  logic signed [SF:0] mag;

  always_comb begin
    pos_d  = pos_q;
    quad_d = quad_q;
    if (clear) begin
      pos_d  = '0;
      quad_d = QD_RISE;
    end else if (step) begin
      if (pos_q == POS_W'(QUARTER - 1)) begin
        pos_d  = '0;
        quad_d = quad_e'(2'(quad_q + 2'd1));
      end else begin
        pos_d = pos_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      quad_q <= QD_RISE;
    end else begin
      pos_q  <= pos_d;
      quad_q <= quad_d;
    end
  end

  assign mirror  = (quad_q == QD_FALL)  || (quad_q == QD_NRISE);
  assign negate  = (quad_q == QD_NFALL) || (quad_q == QD_NRISE);
  assign idx     = mirror ? (IDX_W'(QUARTER) - IDX_W'(pos_q)) : IDX_W'(pos_q);
  assign mag     = $signed({1'b0, tbl[idx]});
  assign sample  = negate ? -mag : mag;
  assign at_zero = (pos_q == '0) && (quad_q == QD_RISE);
endmodule

// File: rtl/tsp_thresh.sv
module tsp_thresh
  import tsp_pkg::*;
#(
  parameter int PERIOD = 12500,
  parameter int TW     = $clog2(PERIOD + 1),
  parameter int KW     = 8,
  parameter int KF     = KF_DEF,
  parameter int GW     = 8,
  parameter int GF     = GF_DEF,
  parameter int SF     = SF_DEF
) (
  input  logic [KW-1:0]      k_set,
  input  logic [GW-1:0]      gain_set,
  input  logic signed [SF:0] sample,
  output logic [TW-1:0]      th_boost,
  output logic [TW-1:0]      th_sine,
  output logic               legal
);
  localparam int AL = GF + SF - KF;  // aligns k with the gain*sample product

  logic signed [63:0] k_ext, a_ext, s_ext, sum;
  logic        [63:0] num1, den1, num2, den2, q1, q2;

  always_comb begin
    k_ext = 64'(k_set);
    a_ext = 64'(gain_set);
    s_ext = 64'(sample);
    sum   = (k_ext <<< AL) + a_ext * s_ext;

    num1 = 64'(k_set) * 64'(PERIOD);
    den1 = 64'(k_set) + 64'(1 << KF);
    q1   = num1 / den1;

    num2 = sum[63] ? 64'd0 : $unsigned(sum) * 64'(PERIOD);
    den2 = den1 << (AL + 1);
    q2   = num2 / den2;
    if (q2 > 64'(PERIOD)) q2 = 64'(PERIOD);
  end

  assign th_boost = TW'(q1);
  assign th_sine  = TW'(q2);
  assign legal    = ((32'(gain_set) << KF) <= (32'(k_set) << GF));
endmodule

// File: rtl/tri_switch_pwm.sv
module tri_switch_pwm
  import tsp_pkg::*;
#(
  parameter int PERIOD  = 12500,  // 250 MHz / 20 kHz
  parameter int QUARTER = 100,    // 400 steps per 50 Hz sine period
  parameter int KW      = 8,
  parameter int KF      = KF_DEF,
  parameter int GW      = 8,
  parameter int GF      = GF_DEF,
  parameter int SF      = SF_DEF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [KW-1:0] k_set,
  input  logic [GW-1:0] gain_set,
  output logic          g_s1,
  output logic          g_s2,
  output logic          g_s3,
  output logic          sine_strobe
);
  localparam int TW = $clog2(PERIOD + 1);

  // reset: asserted asynchronously, released after two clocks
  logic [1:0] rsync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync <= 2'b00;
    else        rsync <= {rsync[0], 1'b1};
  end
  assign rst_s = rsync[1];

  logic [TW-1:0]      cnt;
  logic               wrap;
  logic signed [SF:0] sample;
  logic               at_zero;
  logic [TW-1:0]      th1_c, th2_c;
  logic               legal_c;

  tsp_carrier #(.PERIOD(PERIOD), .TW(TW)) u_carrier (
    .clk(clk), .rst_n(rst_s), .en(en), .cnt(cnt), .wrap(wrap)
  );

  tsp_sine_ref #(.QUARTER(QUARTER), .SF(SF)) u_sine (
    .clk(clk), .rst_n(rst_s), .clear(!en), .step(wrap),
    .sample(sample), .at_zero(at_zero)
  );

  tsp_thresh #(
    .PERIOD(PERIOD), .TW(TW), .KW(KW), .KF(KF), .GW(GW), .GF(GF), .SF(SF)
  ) u_thresh (
    .k_set(k_set), .gain_set(gain_set), .sample(sample),
    .th_boost(th1_c), .th_sine(th2_c), .legal(legal_c)
  );

  logic [TW-1:0] th1_q, th1_d, th2_q, th2_d;
  logic          run_q, run_d, strb_q, strb_d, legal_q, legal_d;

  always_comb begin
    th1_d   = th1_q;
    th2_d   = th2_q;
    legal_d = legal_q;
    run_d   = run_q;
    strb_d  = 1'b0;
    if (!en) begin
      run_d = 1'b0;
    end else if (wrap) begin
      run_d   = 1'b1;
      th1_d   = th1_c;
      th2_d   = th2_c;
      legal_d = legal_c;
      strb_d  = at_zero;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      th1_q   <= '0;
      th2_q   <= '0;
      legal_q <= 1'b0;
      run_q   <= 1'b0;
      strb_q  <= 1'b0;
    end else begin
      th1_q   <= th1_d;
      th2_q   <= th2_d;
      legal_q <= legal_d;
      run_q   <= run_d;
      strb_q  <= strb_d;
    end
  end

  assign g_s1        = run_q && (cnt <  th1_q);
  assign g_s2        = run_q && (cnt >= th2_q);
  assign g_s3        = g_s1 ^ g_s2;
  assign sine_strobe = strb_q;

  // R1: once enable is sampled low, nothing drives
  p_idle_low_r1: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(en) |-> (!g_s1 && !g_s2 && !g_s3 && !sine_strobe));

  // R6: with gain not above boost ratio, exactly two switches conduct
  p_two_on_r6: assert property (@(posedge clk) disable iff (!rst_s)
    (run_q && legal_q) |-> ($countones({g_s1, g_s2, g_s3}) == 2));

  // R7: thresholds move only at a carrier wrap
  p_hold_mid_r7: assert property (@(posedge clk) disable iff (!rst_s)
    !$past(wrap) |-> ($stable(th1_q) && $stable(th2_q)));

  // R8: strobe sits on count zero of a running period
  p_strobe_start_r8: assert property (@(posedge clk) disable iff (!rst_s)
    sine_strobe |-> (cnt == '0 && run_q));

  // R8: strobe is a single-cycle pulse
  p_strobe_single_r8: assert property (@(posedge clk) disable iff (!rst_s)
    sine_strobe |=> !sine_strobe);
endmodule

// File: tb/tri_switch_pwm_tb.sv
module tri_switch_pwm_tb;
  localparam int P  = 64;
  localparam int Q  = 64;
  localparam int N  = 4 * Q;
  localparam int SF = 14;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] k_set = 8'd0;
  logic [7:0] gain_set = 8'd0;
  logic       g_s1, g_s2, g_s3, sine_strobe;

  int vectors = 0;
  int miscompares = 0;
  int cycles = 0;

  tri_switch_pwm #(.PERIOD(P), .QUARTER(Q)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .k_set(k_set), .gain_set(gain_set),
    .g_s1(g_s1), .g_s2(g_s2), .g_s3(g_s3), .sine_strobe(sine_strobe)
  );

  always #2 clk = ~clk;  // 250 MHz

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_th1(input int kv);
    return (longint'(P) * kv) / (kv + 16);
  endfunction

  function automatic longint exp_th2(input int kv, input int av, input int n);
    longint s, sum, t;
    s   = longint'(int'($sin(2.0 * 3.141592653589793 * (n % N) / N) * ((1 << SF) - 1)));
    sum = (longint'(kv) <<< 16) + longint'(av) * s;
    if (sum < 0) sum = 0;
    t = (sum * P) / ((longint'(kv) + 16) <<< 17);
    if (t > P) t = P;
    return t;
  endfunction

  // disable, load settings, enable; returns at cycle 0 of period 0
  task automatic start_run(input int kv, input int av);
    @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    k_set = 8'(kv);
    gain_set = 8'(av);
    en = 1'b1;
    @(negedge clk);
  endtask

  // samples P cycles of period n; optionally changes settings after cycle chg_i
  task automatic measure_period(input int n, input int kv, input int av,
                                input int chg_i, input int nk, input int na);
    longint t1, t2;
    int c1 = 0, c2 = 0;
    bit ok_xor = 1, ok_leg = 1, ok_pos1 = 1, ok_tail2 = 1, seen2 = 0, ok_strb = 1;
    t1 = exp_th1(kv);
    t2 = exp_th2(kv, av, n);
    for (int i = 0; i < P; i++) begin
      c1 += int'(g_s1);
      c2 += int'(g_s2);
      if (g_s3 != (g_s1 ^ g_s2)) ok_xor = 0;
      if ((av <= 4 * kv) && ($countones({g_s1, g_s2, g_s3}) != 2)) ok_leg = 0;
      if (g_s1 != (longint'(i) < t1)) ok_pos1 = 0;
      if (seen2 && !g_s2) ok_tail2 = 0;
      if (g_s2) seen2 = 1;
      if (sine_strobe != ((i == 0) && (n % N == 0))) ok_strb = 0;
      if (i == chg_i) begin
        k_set = 8'(nk);
        gain_set = 8'(na);
      end
      @(negedge clk);
    end
    check(c1 == t1 && ok_pos1, "R3", $sformatf("S1 on-count period %0d", n), c1, t1);
    check((c2 >= P - t2 - 1) && (c2 <= P - t2 + 1) && ok_tail2, "R4",
          $sformatf("S2 on-count period %0d", n), c2, P - t2);
    check(ok_xor, "R5", $sformatf("S3 xor period %0d", n), ok_xor, 1);
    check(ok_leg, "R6", $sformatf("two-on rule period %0d", n), ok_leg, 1);
    check(ok_strb, "R8", $sformatf("strobe period %0d (R2 period length)", n), ok_strb, 1);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check({g_s1, g_s2, g_s3, sine_strobe} == 4'b0, "R1", "outputs in reset",
          {g_s1, g_s2, g_s3, sine_strobe}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check({g_s1, g_s2, g_s3, sine_strobe} == 4'b0, "R1", "outputs disabled",
          {g_s1, g_s2, g_s3, sine_strobe}, 0);
  endtask

  task automatic t_default_full;  // k=2, A=1.75 over a whole sine period
    start_run(32, 112);
    check(sine_strobe == 1'b1, "R9", "strobe right after enable", sine_strobe, 1);
    for (int n = 0; n <= N; n++) measure_period(n, 32, 112, -1, 0, 0);
  endtask

  task automatic t_low_gain;  // k=1, A=0.5
    start_run(16, 32);
    for (int n = 0; n < 40; n++) measure_period(n, 16, 32, -1, 0, 0);
  endtask

  task automatic t_gain_above_k;  // k=0.5, A=1.0: S2 threshold clamps at zero
    start_run(8, 64);
    for (int n = 0; n < N; n++) measure_period(n, 8, 64, -1, 0, 0);
  endtask

  task automatic t_zero_boost;  // k=0, A=0: S1 never on, S2 always on
    start_run(0, 0);
    for (int n = 0; n < 3; n++) measure_period(n, 0, 0, -1, 0, 0);
  endtask

  task automatic t_mid_change;  // R7: new settings wait for the next period
    start_run(32, 112);
    measure_period(0, 32, 112, 10, 16, 32);
    measure_period(1, 16, 32, -1, 0, 0);
    measure_period(2, 16, 32, -1, 0, 0);
    check(1'b1, "R7", "mid-period change verified via periods 0..2", 1, 1);
  endtask

  task automatic t_disable;
    bit quiet = 1;
    start_run(32, 112);
    repeat (20) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    for (int i = 0; i < 6; i++) begin
      if ({g_s1, g_s2, g_s3, sine_strobe} != 4'b0) quiet = 0;
      @(negedge clk);
    end
    check(quiet, "R1", "outputs after enable drop", quiet, 1);
    start_run(32, 112);
    check(sine_strobe == 1'b1, "R9", "phase restarts at sample 0", sine_strobe, 1);
    measure_period(0, 32, 112, -1, 0, 0);
  endtask

  task automatic t_async_reset;
    start_run(32, 112);
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    #1;
    check({g_s1, g_s2, g_s3, sine_strobe} == 4'b0, "R1", "async reset mid-run",
          {g_s1, g_s2, g_s3, sine_strobe}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    t_reset();
    t_default_full();
    t_low_gain();
    t_gain_above_k();
    t_zero_boost();
    t_mid_change();
    t_disable();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule